// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block gathers interrupt events for a processor's fast-interrupt line. It has two banks of 32 bits each. Every bank holds a pending register and an enable register. Each of these registers has two write addresses: one where a written 1 sets the bit and one where a written 1 clears it. Software therefore never has to read a register, change it and write it back. Hardware sources raise pending bits through one 32-bit pulse vector per bank. Software can raise the same bits through the set address to force an interrupt by hand.

The top bit of the first bank is not stored. It reads as a summary that is high whenever any second-bank bit is both pending and enabled. That lets one enable bit in the first bank gate the whole second bank. The single output is a registered request that goes high when any first-bank bit is both pending and enabled. Choosing which source to serve first is left to the interrupt handler.

Top module: `irq_sc_ctrl`

## Requirements
- R1: After reset every pending and enable register reads zero and `fiq` is low.
- R2: A write to a pending-set offset ORs the written mask into that bank's pending bits. Offset 0x40 sets first-bank bits and 0x60 sets second-bank bits. Both offsets and the matching clear offsets (0x44 and 0x64) read back the pending mask.
- R3: A write to a pending-clear offset (0x44 for the first bank, 0x64 for the second) clears the pending bits where the mask is 1 and leaves the other bits unchanged.
- R4: A write to an enable-set offset (0x48, 0x68) sets enable bits, and a write to an enable-clear offset (0x4C, 0x6C) clears them. Both offsets of a bank read back its enable mask.
- R5: A 1 on bit i of `src_a` or `src_b` for one cycle sets pending bit i of that bank, and the bit stays set after the pulse ends.
- R6: When a hardware pulse and a pending-clear write hit the same bit in the same cycle, the bit ends up set.
- R7: First-bank pending bit 31 is read-only. It reads as the OR over all second-bank bits of (pending AND enable). Writes to it and `src_a[31]` have no effect on it.
- R8: `fiq` is registered. One cycle after a register change, it equals the OR over the first bank of (pending AND enable), with bit 31 taken from the R7 summary.
- R9: Offsets other than the eight listed above read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 32 | Write mask |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_a | input | 32 | First-bank hardware event pulses |
| src_b | input | 32 | Second-bank hardware event pulses |
| fiq | output | 1 | Fast-interrupt request |

## Verification
The hardest case to reach is a race on a single pending bit: a clear write and a hardware pulse must land on the same bit in the same cycle. The stimulus table can drive a source pulse together with a clear write in one vector, so this case becomes an ordinary table row. The cascade path is exercised in steps. Second-bank pending and enable are each set on their own. The first bank's gating bit 31 is then toggled. Finally the second-bank cause is removed while the gate stays open. The summary read-back and `fiq` are checked at each step.

// File: rtl/irq_sc_pkg.sv
package irq_sc_pkg;

    localparam int NUM_BANKS   = 2;
    localparam int BANK_STRIDE = 'h20;
    localparam int FIRST_BASE  = 'h40;

    // register kind within a bank, by word index
    typedef enum logic [1:0] {
        KIND_PSET = 2'd0,
        KIND_PCLR = 2'd1,
        KIND_ESET = 2'd2,
        KIND_ECLR = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic      bank;
        reg_kind_e kind;
    } reg_sel_t;

endpackage

// File: rtl/irq_sc_decode.sv
module irq_sc_decode
    import irq_sc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam int KIND_SPAN = 16;

    always_comb begin
        sel = '{hit: 1'b0, bank: 1'b0, kind: KIND_PSET};
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int k = 0; k < 4; k++) begin
                if (int'(addr) == FIRST_BASE + b * BANK_STRIDE + k * 4) begin
                    sel.hit  = 1'b1;
                    sel.bank = b[0];
                    sel.kind = reg_kind_e'(k[1:0]);
                end
            end
        end
    end

    // R9: a decoded offset must lie inside one bank's 16-byte window
    always_comb begin
        if (sel.hit)
            undecoded_range_chk: assert (int'(addr) >= FIRST_BASE &&
                int'(addr) < FIRST_BASE + NUM_BANKS * BANK_STRIDE &&
                (int'(addr) - FIRST_BASE) % BANK_STRIDE < KIND_SPAN);
    end

endmodule

// File: rtl/irq_sc_bank.sv
module irq_sc_bank #(
    parameter int          WIDTH      = 32,
    parameter logic [31:0] STORE_MASK = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pset_we,
    input  logic             pclr_we,
    input  logic             eset_we,
    input  logic             eclr_we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] hw_src,
    output logic [WIDTH-1:0] pend_q,
    output logic [WIDTH-1:0] en_q
);
    localparam logic [WIDTH-1:0] KEEP = STORE_MASK[WIDTH-1:0];

    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] pend_d;
    logic [WIDTH-1:0] en_d;

    always_comb begin
        set_mask = (hw_src | (pset_we ? wdata : '0)) & KEEP;
        clr_mask = pclr_we ? wdata : '0;
        // set has priority over clear so no event is dropped
        pend_d   = ((pend_q & ~clr_mask) | set_mask) & KEEP;
        en_d     = (en_q & ~(eclr_we ? wdata : '0)) | (eset_we ? wdata : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
        end
    end

    // R2
    pset_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pset_we |=> ((pend_q & $past(wdata & KEEP)) == $past(wdata & KEEP)));

    // R3
    pclr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pclr_we |=> ((pend_q & $past(wdata & ~hw_src)) == '0));

    // R5
    hw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_src & KEEP)) |=> ((pend_q & $past(hw_src & KEEP)) == $past(hw_src & KEEP)));

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pclr_we && |(hw_src & wdata & KEEP)) |=>
            ((pend_q & $past(hw_src & wdata & KEEP)) == $past(hw_src & wdata & KEEP)));

    // R4
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eclr_we |=> ((en_q & $past(wdata)) == '0));

endmodule

// File: rtl/irq_sc_ctrl.sv
module irq_sc_ctrl
    import irq_sc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              fiq
);
    localparam int                SUM_BIT  = DATA_W - 1;
    localparam logic [DATA_W-1:0] SUM_ONLY = DATA_W'(1) << SUM_BIT;

    reg_sel_t          sel;
    logic [DATA_W-1:0] pend_q [NUM_BANKS];
    logic [DATA_W-1:0] en_q   [NUM_BANKS];
    logic [DATA_W-1:0] srcs   [NUM_BANKS];
    logic [DATA_W-1:0] pend_view_a;
    logic              cascade;
    logic              fiq_q;

    assign srcs[0] = src_a;
    assign srcs[1] = src_b;

    irq_sc_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr (reg_addr),
        .sel  (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [31:0] MASK = (b == 0) ? 32'(~SUM_ONLY) : 32'hFFFF_FFFF;
        logic bank_hit;
        assign bank_hit = reg_wr && sel.hit && (sel.bank == b[0]);

        irq_sc_bank #(.WIDTH(DATA_W), .STORE_MASK(MASK)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pset_we (bank_hit && sel.kind == KIND_PSET),
            .pclr_we (bank_hit && sel.kind == KIND_PCLR),
            .eset_we (bank_hit && sel.kind == KIND_ESET),
            .eclr_we (bank_hit && sel.kind == KIND_ECLR),
            .wdata   (reg_wdata),
            .hw_src  (srcs[b]),
            .pend_q  (pend_q[b]),
            .en_q    (en_q[b])
        );
    end

    always_comb begin
        cascade     = |(pend_q[1] & en_q[1]);
        pend_view_a = (pend_q[0] & ~SUM_ONLY) | (cascade ? SUM_ONLY : '0);
    end

    always_comb begin
        reg_rdata = '0;
        if (sel.hit) begin
            unique case (sel.kind)
                KIND_PSET, KIND_PCLR: reg_rdata = sel.bank ? pend_q[1] : pend_view_a;
                KIND_ESET, KIND_ECLR: reg_rdata = sel.bank ? en_q[1] : en_q[0];
                default:              reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fiq_q <= 1'b0;
        else        fiq_q <= |(pend_view_a & en_q[0]);
    end

    assign fiq = fiq_q;

    // R7
    summary_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q[1] & en_q[1]) && en_q[0][SUM_BIT]) |=> fiq);

    // R8
    fiq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[0] == '0) |=> !fiq);

    // R9
    always_comb begin
        if (!sel.hit)
            undecoded_zero_chk: assert (reg_rdata == '0);
    end

endmodule

// File: tb/irq_sc_ctrl_tb_top.sv
module irq_sc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        fiq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_sc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_a(src_a),
        .src_b(src_b), .fiq(fiq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] sa;
        logic [31:0] sb;
        logic [7:0]  raddr;
        logic [31:0] exp;
        logic        efiq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 8'h40, 32'h0000_0005, 32'h0, 32'h0, 8'h40, 32'h0000_0005, 1'b0}, // R2
        '{4'd4, 1'b1, 8'h48, 32'h0000_0004, 32'h0, 32'h0, 8'h4C, 32'h0000_0004, 1'b1}, // R4 R8
        '{4'd3, 1'b1, 8'h44, 32'h0000_0004, 32'h0, 32'h0, 8'h44, 32'h0000_0001, 1'b0}, // R3
        '{4'd5, 1'b0, 8'h00, 32'h0,         32'h100, 32'h0, 8'h40, 32'h0000_0101, 1'b0}, // R5
        '{4'd8, 1'b1, 8'h48, 32'h0000_0100, 32'h0, 32'h0, 8'h48, 32'h0000_0104, 1'b1}, // R8
        '{4'd4, 1'b1, 8'h4C, 32'h0000_0100, 32'h0, 32'h0, 8'h48, 32'h0000_0004, 1'b0}, // R4
        '{4'd7, 1'b1, 8'h40, 32'h8000_0000, 32'h0, 32'h0, 8'h40, 32'h0000_0101, 1'b0}, // R7
        '{4'd2, 1'b1, 8'h60, 32'h0001_0000, 32'h0, 32'h0, 8'h64, 32'h0001_0000, 1'b0}, // R2
        '{4'd7, 1'b1, 8'h68, 32'h0001_0000, 32'h0, 32'h0, 8'h40, 32'h8000_0101, 1'b0}, // R7
        '{4'd8, 1'b1, 8'h48, 32'h8000_0000, 32'h0, 32'h0, 8'h4C, 32'h8000_0004, 1'b1}, // R8
        '{4'd3, 1'b1, 8'h64, 32'h0001_0000, 32'h0, 32'h0, 8'h40, 32'h0000_0101, 1'b0}, // R3
        '{4'd4, 1'b1, 8'h6C, 32'h0001_0000, 32'h0, 32'h2, 8'h68, 32'h0000_0000, 1'b0}, // R4 R5
        '{4'd6, 1'b1, 8'h44, 32'h0000_0100, 32'h100, 32'h0, 8'h40, 32'h0000_0101, 1'b0}, // R6
        '{4'd9, 1'b1, 8'h50, 32'hFFFF_FFFF, 32'h0, 32'h0, 8'h50, 32'h0000_0000, 1'b0}, // R9
        '{4'd8, 1'b1, 8'h48, 32'h0000_0001, 32'h0, 32'h0, 8'h48, 32'h8000_0005, 1'b1}, // R8
        '{4'd7, 1'b1, 8'h44, 32'h0000_0001, 32'h8000_0000, 32'h0, 8'h40, 32'h0000_0100, 1'b0}, // R7
        '{4'd7, 1'b1, 8'h68, 32'h0000_0002, 32'h0, 32'h0, 8'h6C, 32'h0000_0002, 1'b1}  // R7 R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, input string tag, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; src_a = '0; src_b = '0;
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        read_at(8'h40, "R1 pend a", 32'h0);
        read_at(8'h48, "R1 en a", 32'h0);
        read_at(8'h60, "R1 pend b", 32'h0);
        read_at(8'h68, "R1 en b", 32'h0);
        check("R1 fiq", {31'h0, fiq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            reg_wr = VECS[i].wr; reg_addr = VECS[i].addr; reg_wdata = VECS[i].data;
            src_a = VECS[i].sa; src_b = VECS[i].sb;
            @(negedge clk);
            idle();
            read_at(VECS[i].raddr, $sformatf("R%0d vec %0d rdata", VECS[i].req, i), VECS[i].exp);
            @(negedge clk);
            check($sformatf("R%0d vec %0d fiq", VECS[i].req, i), {31'h0, fiq}, {31'h0, VECS[i].efiq});
        end

        // R9: undecoded offset 0x70 reads zero; write there leaves bank B intact
        reg_wr = 1'b1; reg_addr = 8'h70; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        idle();
        read_at(8'h70, "R9 undecoded read", 32'h0);
        read_at(8'h60, "R9 bank b untouched", 32'h0000_0002);
        read_at(8'h48, "R9 bank a enable untouched", 32'h8000_0005);

        // R1: reset mid-run returns all to zero
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_at(8'h44, "R1 pend a after reset", 32'h0);
        read_at(8'h6C, "R1 en b after reset", 32'h0);
        check("R1 fiq after reset", {31'h0, fiq}, 32'h0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule